// File: doc/BRIEF.md
# Adaptive Non-Overlap Half-Bridge Gate Sequencer

This block drives the two gate enables of a synchronous buck half-bridge from a three-level PWM command. The command arrives already decoded into high, low or a mid-level shutdown window. A high command turns the upper gate on and the lower gate off. A low command does the reverse. The mid level turns both gates off. The block never turns both gates on together. It also does not rely on a fixed dead time. Before turning a gate on, it waits for digitized comparator feedback showing that the opposite gate has really discharged.

The command, the enable, the supply-good flag and the three comparator flags each pass through a two-flop synchronizer before the state machine uses them. Three comparator flags are used:

- The upper gate-to-switch-node voltage is below 1.1 V.
- The switch node is below 2 V.
- The lower gate is below 1.1 V.

A programmable timeout can release a pending turn-on if the confirming flag never arrives. A sticky status bit records that this fallback was taken. Dropping the enable or the supply-good flag forces both gates off. When both come back, sequencing restarts from the all-off state.

The state machine has five states:

- OFF: both gates off.
- WAIT_LS_OFF: both gates off, waiting for proof that the lower gate is off.
- HS_ON: upper gate on.
- WAIT_HS_OFF: both gates off, waiting for proof that the upper gate is off.
- LS_ON: lower gate on.

Transitions while running:

- A high command moves OFF or LS_ON to WAIT_LS_OFF.
- WAIT_LS_OFF moves to HS_ON when the lower-gate flag is seen or the timeout expires.
- A low command moves OFF or HS_ON to WAIT_HS_OFF.
- WAIT_HS_OFF moves to LS_ON when either the upper gate-to-switch-node flag or the switch-node flag is seen, or the timeout expires.
- A reversed command moves one wait state directly into the other.
- A mid command moves any state to OFF.
- Loss of enable or supply-good moves any state to OFF.

Top module: `hb_gate_seq`

## Requirements
- R1: `pwm_cmd` encoding is 2'b10 = high, 2'b00 = low, and 2'b01 or 2'b11 = mid-level shutdown. A mid command drives both `hs_gate` and `ls_gate` low.
- R2: A steady high command with the lower-gate flag present ends with `hs_gate`=1 and `ls_gate`=0.
- R3: A steady low command with its turn-on condition met ends with `hs_gate`=0 and `ls_gate`=1.
- R4: `hs_gate` and `ls_gate` are never both 1. Every handover between them passes through at least one cycle with both at 0.
- R5: `hs_gate` may only rise after `ls_g_low` has been seen. While `ls_g_low` stays 0 and the timeout is off, the gates stay at 0.
- R6: `ls_gate` may only rise after `hs_gs_low` or `sw_low` has been seen. Either flag alone is sufficient.
- R7: With `drv_en`=0, both gates are 0. When `drv_en` returns to 1, the sequence restarts from the all-off state and goes through a wait state before any gate turns on.
- R8: With `supply_ok`=0, both gates are 0 whatever the other inputs are.
- R9: An input change presented before rising edge 1 reaches the gates at rising edge 3 (two synchronizer stages plus the state register). A gate turn-on that follows an off edge comes one edge later, at the earliest.
- R10: With a nonzero `tmo_limit` L, a pending turn-on whose flag never arrives happens after exactly L cycles in the wait state. With `tmo_limit`=0 the controller waits indefinitely.
- R11: A command reversal during a wait state abandons the pending turn-on and enters the opposite wait state with both gates off. The timeout count restarts from zero on every command change.
- R12: `tmo_used` is set at the edge where a timeout releases a gate. It is not set when a flag releases a gate, and it stays set until reset.
- R13: While `rst_n` is 0, `hs_gate`, `ls_gate` and `tmo_used` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 2 | Decoded PWM level (10 high, 00 low, 01/11 shutdown) |
| drv_en | input | 1 | Driver enable; low forces both gates off |
| supply_ok | input | 1 | Supply-good flag; low forces both gates off |
| hs_gs_low | input | 1 | Upper gate-to-switch-node voltage below 1.1 V |
| sw_low | input | 1 | Switch node below 2 V |
| ls_g_low | input | 1 | Lower gate below 1.1 V |
| tmo_limit | input | TMO_W | Wait-state timeout in cycles; 0 disables it |
| hs_gate | output | 1 | Upper gate enable |
| ls_gate | output | 1 | Lower gate enable |
| tmo_used | output | 1 | Sticky: a timeout fallback has released a gate |

## Verification
Every result is due a fixed number of rising edges after its stimulus:

- An off decision (mid command, lost enable, lost supply, command change) shows at the third edge.
- A confirmed turn-on shows at the fourth edge.
- A timeout-released turn-on shows L edges after the wait state is entered, that is, at edge 3+L.

The table rows wait six edges so that every path has settled. The directed tests sample at the negative edge just before and just after each due edge. This pins down the latency, the all-off gap, the timeout length and the counter restart on a reversal.

// File: rtl/hb_gate_seq_pkg.sv
package hb_gate_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,
        ST_HS_ON       = 3'd1,
        ST_WAIT_LS_OFF = 3'd2,
        ST_LS_ON       = 3'd3,
        ST_WAIT_HS_OFF = 3'd4
    } seq_state_t;

    localparam logic [1:0] CMD_LOW  = 2'b00;
    localparam logic [1:0] CMD_HIGH = 2'b10;

    localparam int SYNC_STAGES = 2;
    localparam int SYNC_BITS   = 7;

endpackage

// File: rtl/hb_gate_seq_sync.sv
module hb_gate_seq_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/hb_gate_seq_timer.sv
module hb_gate_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr)             cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (limit != '0) && (cnt_q >= (limit - 1'b1));

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hb_gate_seq_pkg::*;
#(
    parameter int TMO_W  = 8,
    parameter bit TMO_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pwm_cmd,
    input  logic             drv_en,
    input  logic             supply_ok,
    input  logic             hs_gs_low,
    input  logic             sw_low,
    input  logic             ls_g_low,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             hs_gate,
    output logic             ls_gate,
    output logic             tmo_used
);

    logic [SYNC_BITS-1:0] raw_in, syn_in;
    logic [1:0]  cmd_s, cmd_prev_q;
    logic        run_s, hs_off_seen, ls_off_seen;
    logic        cmd_hi, cmd_lo, cmd_chg, in_wait;
    logic        tmo_exp, take_tmo;
    seq_state_t  state_q, state_d;

    assign raw_in = {pwm_cmd, drv_en, supply_ok, hs_gs_low, sw_low, ls_g_low};

    hb_gate_seq_sync #(.W(SYNC_BITS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .d_sync  (syn_in)
    );

    assign cmd_s       = syn_in[6:5];
    assign run_s       = syn_in[4] & syn_in[3];
    assign hs_off_seen = syn_in[2] | syn_in[1];
    assign ls_off_seen = syn_in[0];

    assign cmd_hi = (cmd_s == CMD_HIGH);
    assign cmd_lo = (cmd_s == CMD_LOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_prev_q <= CMD_LOW;
        else        cmd_prev_q <= cmd_s;
    end
    assign cmd_chg = (cmd_s != cmd_prev_q);

    assign in_wait = (state_q == ST_WAIT_LS_OFF) || (state_q == ST_WAIT_HS_OFF);

    generate
        if (TMO_EN) begin : g_tmo
            hb_gate_seq_timer #(.TW(TMO_W)) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (!in_wait || cmd_chg),
                .limit   (tmo_limit),
                .expired (tmo_exp)
            );
        end else begin : g_no_tmo
            assign tmo_exp = 1'b0;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run_s) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (cmd_hi)      state_d = ST_WAIT_LS_OFF;
                    else if (cmd_lo) state_d = ST_WAIT_HS_OFF;
                end
                ST_HS_ON: begin
                    if (cmd_lo)       state_d = ST_WAIT_HS_OFF;
                    else if (!cmd_hi) state_d = ST_OFF;
                end
                ST_LS_ON: begin
                    if (cmd_hi)       state_d = ST_WAIT_LS_OFF;
                    else if (!cmd_lo) state_d = ST_OFF;
                end
                ST_WAIT_LS_OFF: begin
                    if (cmd_lo)                          state_d = ST_WAIT_HS_OFF;
                    else if (!cmd_hi)                    state_d = ST_OFF;
                    else if (ls_off_seen || tmo_exp)     state_d = ST_HS_ON;
                end
                ST_WAIT_HS_OFF: begin
                    if (cmd_hi)                          state_d = ST_WAIT_LS_OFF;
                    else if (!cmd_lo)                    state_d = ST_OFF;
                    else if (hs_off_seen || tmo_exp)     state_d = ST_LS_ON;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    assign take_tmo = run_s && tmo_exp &&
        (((state_q == ST_WAIT_LS_OFF) && cmd_hi && !ls_off_seen) ||
         ((state_q == ST_WAIT_HS_OFF) && cmd_lo && !hs_off_seen));

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_gate  <= 1'b0;
            ls_gate  <= 1'b0;
            tmo_used <= 1'b0;
        end else begin
            hs_gate <= (state_d == ST_HS_ON);
            ls_gate <= (state_d == ST_LS_ON);
            if (take_tmo) tmo_used <= 1'b1;
        end
    end

endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_gate,
    input logic       ls_gate,
    input logic       tmo_used,
    input logic [1:0] cmd_s,
    input logic       run_s,
    input logic       hs_off_seen,
    input logic       ls_off_seen,
    input logic       tmo_exp
);

    // R4
    never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R4
    hs_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> !$past(ls_gate));

    // R5
    hs_confirmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> $past(ls_off_seen || tmo_exp));

    // R6
    ls_confirmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> $past(hs_off_seen || tmo_exp));

    // R1
    mid_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_s[0] == 1'b1) |=> (!hs_gate && !ls_gate));

    // R8
    halt_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |=> (!hs_gate && !ls_gate));

    // R12
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_used |=> tmo_used);

endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .tmo_used    (tmo_used),
    .cmd_s       (cmd_s),
    .run_s       (run_s),
    .hs_off_seen (hs_off_seen),
    .ls_off_seen (ls_off_seen),
    .tmo_exp     (tmo_exp)
);

// File: tb/hb_gate_seq_test.sv
module hb_gate_seq_test;

    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    pwm_cmd;
    logic          drv_en, supply_ok, hs_gs_low, sw_low, ls_g_low;
    logic [TW-1:0] tmo_limit;
    logic          hs_gate, ls_gate, tmo_used;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hb_gate_seq #(.TMO_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .drv_en(drv_en),
        .supply_ok(supply_ok), .hs_gs_low(hs_gs_low), .sw_low(sw_low),
        .ls_g_low(ls_g_low), .tmo_limit(tmo_limit),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .tmo_used(tmo_used)
    );

    // {cmd[1:0], en, sup, hsf, swf, lsf, exp_hs, exp_ls, exp_tmo}
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        10'b10_1_1_0_0_1_100,
        10'b00_1_1_1_0_0_010,
        10'b01_1_1_1_0_0_000,
        10'b10_1_1_0_0_0_000,
        10'b10_1_1_0_0_1_100,
        10'b00_1_1_0_0_0_000,
        10'b00_1_1_0_1_0_010,
        10'b11_1_1_0_1_0_000,
        10'b00_0_1_0_1_0_000,
        10'b00_1_1_0_1_0_010,
        10'b00_1_0_0_1_0_000,
        10'b10_1_1_0_0_1_100
    };
    string row_tag [NV];

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {hs_gate, ls_gate, tmo_used};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {hs,ls,tmo} got %b expected %b", req, act, exp);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        row_tag = '{"R2 R5", "R3 R6", "R1", "R5", "R5", "R6", "R6", "R1",
                    "R7", "R7", "R8", "R2"};
        rst_n = 1'b0; pwm_cmd = 2'b01; drv_en = 1'b1; supply_ok = 1'b1;
        hs_gs_low = 1'b0; sw_low = 1'b0; ls_g_low = 1'b0; tmo_limit = '0;
        edges(3);
        chk("R13 reset", 3'b000);
        rst_n = 1'b1;
        edges(2);

        for (int i = 0; i < NV; i++) begin
            {pwm_cmd, drv_en, supply_ok, hs_gs_low, sw_low, ls_g_low} = VEC[i][9:3];
            edges(6);
            chk($sformatf("%s row %0d", row_tag[i], i), VEC[i][2:0]);
        end

        // R9 / R4: upper gate on; switch to low with the upper-off flag present
        pwm_cmd = 2'b00; hs_gs_low = 1'b1;
        edges(2);
        chk("R9 before third edge", 3'b100);
        edges(1);
        chk("R4 all-off gap", 3'b000);
        edges(1);
        chk("R9 turn-on one edge later", 3'b010);
        chk("R12 flag release leaves status clear", 3'b010);

        // R10: timeout releases upper gate after 5 wait cycles
        tmo_limit = 8'd5; hs_gs_low = 1'b0; ls_g_low = 1'b0; pwm_cmd = 2'b10;
        edges(7);
        chk("R10 still waiting", 3'b000);
        edges(1);
        chk("R10 R12 timeout release", 3'b101);

        // R11: reversal mid-wait restarts the count
        pwm_cmd = 2'b00;
        edges(5);
        pwm_cmd = 2'b10;
        edges(7);
        chk("R11 count restarted", 3'b001);
        edges(1);
        chk("R11 opposite turn-on", 3'b101);

        // R10: timeout disabled waits indefinitely
        tmo_limit = '0; pwm_cmd = 2'b00;
        edges(40);
        chk("R10 disabled timeout", 3'b001);

        // R7: enable restart through all-off
        pwm_cmd = 2'b10; ls_g_low = 1'b1;
        edges(6);
        chk("R2 upper on", 3'b101);
        drv_en = 1'b0;
        edges(5);
        chk("R7 disabled", 3'b001);
        drv_en = 1'b1;
        edges(3);
        chk("R7 restart gap", 3'b001);
        edges(1);
        chk("R7 restart on", 3'b101);

        // R13: reset mid-run
        rst_n = 1'b0;
        edges(1);
        chk("R13 reset mid-run", 3'b000);

        report();
    end

endmodule